// File: doc/BRIEF.md
# Memory Ordering Issue Gate

This block sits between an in-order queue of memory operations and a memory port that may finish requests in any order. Each operation enters with an address, an access type (read, write, flush or atomic read-modify-write) and an ordering class (unordered, acquire, release or fence). The block holds up to eight operations. In each cycle it issues at most one of them: the oldest one that the ordering classes and the same-line data hazards allow. Each issued operation carries a tag. The memory port later returns that tag as a completion, and completions may come back in any order.

The ordering classes follow a one-way matrix. An acquire holds back everything younger than it. A release waits for everything older than it. A fence does both. A release does not hold back a younger acquire or a younger unordered access. Apart from these classes, accesses that fall in the same 32-byte line are kept in program order whenever at least one of them writes. An atomic operation goes out as a read beat followed, in the very next cycle, by a write beat with the same tag and address, and nothing else is issued between the two beats.

Top module: `mo_issue_gate`

## Requirements
- R1: After reset, `enq_ready` is 1 and `iss_valid` is 0.
- R2: Tags are handed out in enqueue order as the enqueue count modulo 8. An enqueue is accepted at a rising edge where `enq_valid` and `enq_ready` are both 1. `enq_ready` is 1 only while fewer than 8 entries are held. An entry is held from the edge that accepts it until the edge after the one at which both it and every older entry have completed. A completion names a tag that has been fully issued and has not yet been acknowledged.
- R3: At most one beat is issued per cycle, and it comes from the oldest waiting entry that is eligible. An entry can issue at the earliest in the cycle after the edge that accepts it. A completion takes effect for eligibility in the cycle after its edge. Encodings: `enq_kind` 0 read, 1 write, 2 flush, 3 atomic; `enq_order` 0 unordered, 1 acquire, 2 release, 3 fence; `iss_kind` 0 read, 1 write, 2 flush.
- R4: Unordered accesses to different lines issue without waiting for earlier unordered accesses to complete.
- R5: A release or fence issues only once every older entry has completed.
- R6: No entry younger than an outstanding acquire or fence issues until that acquire or fence completes.
- R7: An older release does not hold back a younger acquire or unordered access to a different line.
- R8: Two accesses share a line when `addr[31:5]` is equal. If at least one of them is a write, flush or atomic, the younger one waits until the older one completes.
- R9: Two reads to the same line are not ordered against each other.
- R10: An atomic entry issues a read beat (`iss_kind` 0) and, in the next cycle, a write beat (`iss_kind` 1) with the same tag and address. No other beat comes between them, and the tag is completed only once, after the write beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | An operation is offered for enqueue |
| enq_ready | output | 1 | Fewer than 8 entries are held |
| enq_addr | input | 32 | Byte address of the operation |
| enq_kind | input | 2 | Access type |
| enq_order | input | 2 | Ordering class |
| cpl_valid | input | 1 | A completion is returned this cycle |
| cpl_tag | input | 3 | Tag being completed |
| iss_valid | output | 1 | A beat is issued this cycle |
| iss_tag | output | 3 | Tag of the issued beat |
| iss_addr | output | 32 | Address of the issued beat |
| iss_kind | output | 2 | Beat type: read, write or flush |

## Verification
The bench keeps a behavioural model, compares it against the design on every cycle, and adds directed cases for specific corners. One case is a release followed by an acquire: a design that treated the matrix as symmetric would hold back the acquire. Other cases are a fence placed between unordered reads, and a write followed by a read of the same line at a different byte offset: a design that compared full addresses would let the read slip past the write. It also checks that two reads of one line both issue, and that a flush counts as a write. Further cases are an atomic followed by an eligible read, where an intruding beat would break the pair; a full queue whose ninth operation must wait and then reuse the first tag; and a long random mix in which completions return in an arbitrary order.

// File: rtl/mo_pkg.sv
package mo_pkg;

    typedef enum logic [1:0] {
        K_READ   = 2'd0,
        K_WRITE  = 2'd1,
        K_FLUSH  = 2'd2,
        K_ATOMIC = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        O_UNORD = 2'd0,
        O_ACQ   = 2'd1,
        O_REL   = 2'd2,
        O_FENCE = 2'd3
    } ord_e;

    typedef enum logic [1:0] {
        S_FREE = 2'd0,
        S_WAIT = 2'd1,
        S_BUSY = 2'd2,
        S_DONE = 2'd3
    } st_e;

    typedef struct packed {
        kind_e kind;
        ord_e  ord;
    } attr_t;

    // Ordering-class rule: does an open older entry hold back a younger one?
    function automatic logic order_blocks(ord_e older, ord_e younger);
        logic young_waits_all;
        logic old_gates_rest;
        young_waits_all = (younger == O_REL) || (younger == O_FENCE);
        old_gates_rest  = (older == O_ACQ) || (older == O_FENCE);
        return young_waits_all || old_gates_rest;
    endfunction

    // Data hazard on one line exists unless both sides only read.
    function automatic logic kinds_conflict(kind_e older, kind_e younger);
        return !((older == K_READ) && (younger == K_READ));
    endfunction

endpackage

// File: rtl/mo_queue.sv
module mo_queue
    import mo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_fire,
    input  logic [ADDR_W-1:0] enq_addr,
    input  attr_t             enq_attr,
    input  logic              iss_fire,
    input  logic [PTR_W-1:0]  iss_slot,
    input  logic              cpl_valid,
    input  logic [PTR_W-1:0]  cpl_tag,
    output logic [ADDR_W-1:0] addr_q [DEPTH],
    output attr_t             attr_q [DEPTH],
    output st_e               st_q   [DEPTH],
    output logic [PTR_W-1:0]  head_q,
    output logic [CNT_W-1:0]  count_q
);

    logic [DEPTH-1:0] ret_mask;
    logic [CNT_W-1:0] lead;
    logic [PTR_W-1:0] tail;

    assign tail = head_q + count_q[PTR_W-1:0];

    // Count the run of completed entries at the oldest end; they leave together.
    always_comb begin
        logic             run;
        logic [PTR_W-1:0] s;
        ret_mask = '0;
        lead     = '0;
        run      = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            s = head_q + PTR_W'(k);
            if (run && (CNT_W'(k) < count_q) && (st_q[s] == S_DONE)) begin
                ret_mask[s] = 1'b1;
                lead        = lead + CNT_W'(1);
            end else begin
                run = 1'b0;
            end
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i]   <= S_FREE;
                addr_q[i] <= '0;
                attr_q[i] <= '0;
            end else begin
                if (ret_mask[i]) begin
                    st_q[i] <= S_FREE;
                end
                if (iss_fire && (iss_slot == PTR_W'(i))) begin
                    st_q[i] <= S_BUSY;
                end
                if (cpl_valid && (cpl_tag == PTR_W'(i))) begin
                    st_q[i] <= S_DONE;
                end
                if (enq_fire && (tail == PTR_W'(i))) begin
                    st_q[i]   <= S_WAIT;
                    addr_q[i] <= enq_addr;
                    attr_q[i] <= enq_attr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= head_q + lead[PTR_W-1:0];
            count_q <= count_q - lead + CNT_W'(enq_fire);
        end
    end

    // R2: occupancy never exceeds capacity
    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R2: a new entry only lands in a free slot
    a_r2_enq_into_free: assert property (@(posedge clk) disable iff (rst)
        enq_fire |-> st_q[tail] == S_FREE);

    // R2: a completion names an outstanding tag
    a_r2_cpl_outstanding: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> st_q[cpl_tag] == S_BUSY);

endmodule

// File: rtl/mo_picker.sv
module mo_picker
    import mo_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int LINE_W = 27,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic [LINE_W-1:0] line_q [DEPTH],
    input  attr_t             attr_q [DEPTH],
    input  st_e               st_q   [DEPTH],
    input  logic [PTR_W-1:0]  head_q,
    input  logic [CNT_W-1:0]  count_q,
    output logic              pick_valid,
    output logic [PTR_W-1:0]  pick_slot
);

    logic [DEPTH-1:0] elig;
    logic [PTR_W-1:0] age_slot [DEPTH];

    // For each age position, check every older open entry for an ordering
    // or same-line hazard.
    always_comb begin
        logic blk;
        logic same_line;
        for (int k = 0; k < DEPTH; k++) begin
            age_slot[k] = head_q + PTR_W'(k);
        end
        for (int k = 0; k < DEPTH; k++) begin
            blk = 1'b0;
            for (int m = 0; m < k; m++) begin
                same_line = (line_q[age_slot[m]] == line_q[age_slot[k]]);
                if (st_q[age_slot[m]] != S_DONE) begin
                    if (order_blocks(attr_q[age_slot[m]].ord, attr_q[age_slot[k]].ord)) begin
                        blk = 1'b1;
                    end
                    if (same_line && kinds_conflict(attr_q[age_slot[m]].kind,
                                                    attr_q[age_slot[k]].kind)) begin
                        blk = 1'b1;
                    end
                end
            end
            elig[k] = (CNT_W'(k) < count_q) && (st_q[age_slot[k]] == S_WAIT) && !blk;
        end
    end

    // Oldest eligible wins.
    always_comb begin
        pick_valid = 1'b0;
        pick_slot  = head_q;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (elig[k]) begin
                pick_valid = 1'b1;
                pick_slot  = age_slot[k];
            end
        end
    end

endmodule

// File: rtl/mo_issue_gate.sv
module mo_issue_gate
    import mo_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    localparam int TAG_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [1:0]        enq_kind,
    input  logic [1:0]        enq_order,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    output logic              iss_valid,
    output logic [TAG_W-1:0]  iss_tag,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [1:0]        iss_kind
);

    localparam int LINE_LSB = $clog2(LINE_BYTES);
    localparam int LINE_W   = ADDR_W - LINE_LSB;
    localparam int CNT_W    = TAG_W + 1;

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [LINE_W-1:0] line_q [DEPTH];
    attr_t             attr_q [DEPTH];
    st_e               st_q   [DEPTH];
    logic [TAG_W-1:0]  head_q;
    logic [CNT_W-1:0]  count_q;

    logic              pick_valid;
    logic [TAG_W-1:0]  pick_slot;
    logic              pick_fire;
    logic              enq_fire;
    attr_t             enq_attr;

    logic              awr_pend_q;
    logic [TAG_W-1:0]  awr_tag_q;
    logic [ADDR_W-1:0] awr_addr_q;

    assign enq_ready = (count_q < CNT_W'(DEPTH));
    assign enq_fire  = enq_valid && enq_ready;
    assign enq_attr  = '{kind: kind_e'(enq_kind), ord: ord_e'(enq_order)};

    for (genvar i = 0; i < DEPTH; i++) begin : g_line
        assign line_q[i] = addr_q[i][ADDR_W-1:LINE_LSB];
    end

    mo_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .enq_fire (enq_fire),
        .enq_addr (enq_addr),
        .enq_attr (enq_attr),
        .iss_fire (pick_fire),
        .iss_slot (pick_slot),
        .cpl_valid(cpl_valid),
        .cpl_tag  (cpl_tag),
        .addr_q   (addr_q),
        .attr_q   (attr_q),
        .st_q     (st_q),
        .head_q   (head_q),
        .count_q  (count_q)
    );

    mo_picker #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_picker (
        .line_q    (line_q),
        .attr_q    (attr_q),
        .st_q      (st_q),
        .head_q    (head_q),
        .count_q   (count_q),
        .pick_valid(pick_valid),
        .pick_slot (pick_slot)
    );

    // A pending atomic write beat owns the port for one cycle.
    assign pick_fire = pick_valid && !awr_pend_q;

    always_comb begin
        iss_valid = awr_pend_q || pick_valid;
        if (awr_pend_q) begin
            iss_tag  = awr_tag_q;
            iss_addr = awr_addr_q;
            iss_kind = K_WRITE;
        end else begin
            iss_tag  = pick_slot;
            iss_addr = addr_q[pick_slot];
            iss_kind = (attr_q[pick_slot].kind == K_ATOMIC) ? K_READ : attr_q[pick_slot].kind;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            awr_pend_q <= 1'b0;
            awr_tag_q  <= '0;
            awr_addr_q <= '0;
        end else begin
            awr_pend_q <= pick_fire && (attr_q[pick_slot].kind == K_ATOMIC);
            if (pick_fire) begin
                awr_tag_q  <= pick_slot;
                awr_addr_q <= addr_q[pick_slot];
            end
        end
    end

    // R10: the read beat of an atomic is followed at once by its write beat
    a_r10_write_beat: assert property (@(posedge clk) disable iff (rst)
        (pick_fire && attr_q[pick_slot].kind == K_ATOMIC && iss_kind == K_READ)
        |=> (iss_valid && iss_kind == K_WRITE && iss_tag == $past(iss_tag)
             && iss_addr == $past(iss_addr)));

    // R3: a fresh beat always comes from an entry still waiting in the queue
    a_r3_issue_from_wait: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !awr_pend_q) |-> st_q[iss_tag] == S_WAIT);

endmodule

// File: tb/mo_issue_gate_tb.sv
module mo_issue_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enq_valid = 1'b0;
    logic        enq_ready;
    logic [31:0] enq_addr = '0;
    logic [1:0]  enq_kind = '0;
    logic [1:0]  enq_order = '0;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_tag = '0;
    logic        iss_valid;
    logic [2:0]  iss_tag;
    logic [31:0] iss_addr;
    logic [1:0]  iss_kind;

    always #5 clk = ~clk;

    mo_issue_gate dut_i (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_addr(enq_addr), .enq_kind(enq_kind), .enq_order(enq_order),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
        .iss_valid(iss_valid), .iss_tag(iss_tag),
        .iss_addr(iss_addr), .iss_kind(iss_kind)
    );

    // model entry states: 0 waiting, 1 read beat sent, 2 outstanding, 3 done
    typedef struct { int tag; logic [31:0] addr; int kind; int ord; int st; } ment_t;
    typedef struct { logic [31:0] addr; int kind; int ord; } stim_t;
    typedef struct { int tag; int kind; } lg_t;

    ment_t mq[$];
    stim_t sq[$];
    int    cpl_req[$];
    lg_t   log_q[$];
    bit    obs[8];
    int    mode = 0;
    int    next_tag = 0;
    int    checks = 0;
    int    errors = 0;
    int    base = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit blocks(ment_t o, ment_t y);
        bit ordb, haz;
        ordb = (y.ord == 2) || (y.ord == 3) || (o.ord == 1) || (o.ord == 3);
        haz  = ((o.addr >> 5) == (y.addr >> 5)) && !(o.kind == 0 && y.kind == 0);
        return ordb || haz;
    endfunction

    task automatic step();
        bit e_ready, e_valid, e_half, enq_acc, elig;
        int e_idx, e_kind, nret, pick;
        int busy[$];
        @(negedge clk);
        enq_valid = (sq.size() > 0);
        if (sq.size() > 0) begin
            enq_addr  = sq[0].addr;
            enq_kind  = 2'(sq[0].kind);
            enq_order = 2'(sq[0].ord);
        end
        cpl_valid = 1'b0;
        for (int i = 0; i < mq.size(); i++) if (mq[i].st == 2) busy.push_back(i);
        if (cpl_req.size() > 0) begin
            foreach (busy[i]) begin
                if (!cpl_valid && mq[busy[i]].tag == cpl_req[0]) begin
                    cpl_valid = 1'b1;
                    cpl_tag   = 3'(cpl_req[0]);
                end
            end
            if (cpl_valid) void'(cpl_req.pop_front());
        end else if (mode == 1 && busy.size() > 0 && ($urandom % 3) != 0) begin
            pick      = int'($urandom % busy.size());
            cpl_valid = 1'b1;
            cpl_tag   = 3'(mq[busy[pick]].tag);
        end
        #1;
        e_ready = (mq.size() < 8);
        e_valid = 0; e_half = 0; e_idx = -1; e_kind = 0;
        for (int i = 0; i < mq.size(); i++) begin
            if (mq[i].st == 1) begin
                e_valid = 1; e_half = 1; e_idx = i; e_kind = 1;
            end
        end
        if (!e_valid) begin
            for (int i = 0; i < mq.size(); i++) begin
                if (!e_valid && mq[i].st == 0) begin
                    elig = 1;
                    for (int j = 0; j < i; j++)
                        if (mq[j].st != 3 && blocks(mq[j], mq[i])) elig = 0;
                    if (elig) begin
                        e_valid = 1; e_idx = i;
                        e_kind  = (mq[i].kind == 3) ? 0 : mq[i].kind;
                    end
                end
            end
        end
        chk("R2", "enq_ready", enq_ready, e_ready);
        chk(e_half ? "R10" : "R3", "iss_valid", iss_valid, e_valid);
        if (e_valid) begin
            chk(e_half ? "R10" : "R3", "iss_tag", iss_tag, mq[e_idx].tag);
            chk(e_half ? "R10" : "R3", "iss_addr", iss_addr, mq[e_idx].addr);
            chk(e_half ? "R10" : "R3", "iss_kind", iss_kind, e_kind);
        end
        @(posedge clk);
        enq_acc = enq_valid && e_ready;
        nret = 0;
        while (nret < mq.size() && mq[nret].st == 3) nret++;
        if (e_valid) mq[e_idx].st = e_half ? 2 : ((mq[e_idx].kind == 3) ? 1 : 2);
        if (cpl_valid)
            for (int i = 0; i < mq.size(); i++)
                if (mq[i].tag == int'(cpl_tag) && mq[i].st == 2) mq[i].st = 3;
        repeat (nret) void'(mq.pop_front());
        if (enq_acc) begin
            mq.push_back('{tag: next_tag, addr: sq[0].addr, kind: sq[0].kind, ord: sq[0].ord, st: 0});
            next_tag = (next_tag + 1) % 8;
            void'(sq.pop_front());
        end
        if (iss_valid) begin
            obs[iss_tag] = 1'b1;
            log_q.push_back('{tag: int'(iss_tag), kind: int'(iss_kind)});
        end
    endtask

    task automatic run(input int n);
        repeat (n) step();
    endtask

    task automatic push(input logic [31:0] a, input int k, input int o);
        sq.push_back('{addr: a, kind: k, ord: o});
    endtask

    task automatic drain();
        int guard = 0;
        mode = 1;
        while ((sq.size() > 0 || mq.size() > 0 || cpl_req.size() > 0) && guard < 5000) begin
            step();
            guard++;
        end
        mode = 0;
        step();
        foreach (obs[i]) obs[i] = 1'b0;
        log_q.delete();
        base = next_tag;
    endtask

    function automatic int t(input int i);
        return (base + i) % 8;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "enq_ready after reset", enq_ready, 1);
        chk("R1", "iss_valid after reset", iss_valid, 0);
        foreach (obs[i]) obs[i] = 1'b0;

        // R4: unordered reads to different lines all go out with nothing completed
        push(32'h500, 0, 0); push(32'h520, 0, 0); push(32'h540, 0, 0);
        run(6);
        chk("R4", "unordered t0", obs[t(0)], 1);
        chk("R4", "unordered t1", obs[t(1)], 1);
        chk("R4", "unordered t2", obs[t(2)], 1);
        drain();

        // R5: release waits for older write
        push(32'h20, 1, 0); push(32'h40, 1, 2);
        run(6);
        chk("R5", "older write out", obs[t(0)], 1);
        chk("R5", "release held", obs[t(1)], 0);
        cpl_req.push_back(t(0)); run(4);
        chk("R5", "release after completion", obs[t(1)], 1);
        drain();

        // R6: acquire holds back younger read
        push(32'h60, 0, 1); push(32'h80, 0, 0);
        run(6);
        chk("R6", "younger held by acquire", obs[t(1)], 0);
        cpl_req.push_back(t(0)); run(4);
        chk("R6", "younger after acquire done", obs[t(1)], 1);
        drain();

        // R5/R6: fence in the middle
        push(32'hA0, 0, 0); push(32'hC0, 1, 3); push(32'hE0, 0, 0);
        run(6);
        chk("R5", "fence waits", obs[t(1)], 0);
        chk("R6", "after fence waits", obs[t(2)], 0);
        cpl_req.push_back(t(0)); run(4);
        chk("R5", "fence issued", obs[t(1)], 1);
        chk("R6", "still behind fence", obs[t(2)], 0);
        cpl_req.push_back(t(1)); run(4);
        chk("R6", "after fence done", obs[t(2)], 1);
        drain();

        // R7: release then acquire is not ordered
        push(32'h100, 1, 2); push(32'h120, 0, 1); push(32'h140, 0, 0); push(32'h160, 1, 2);
        run(8);
        chk("R7", "release out", obs[t(0)], 1);
        chk("R7", "acquire passes release", obs[t(1)], 1);
        chk("R6", "behind acquire", obs[t(2)], 0);
        chk("R5", "second release held", obs[t(3)], 0);
        drain();
        push(32'h180, 1, 2); push(32'h1A0, 0, 0);
        run(6);
        chk("R7", "unordered passes release", obs[t(1)], 1);
        drain();

        // R8/R9: line hazards
        push(32'h200, 1, 0); push(32'h21C, 0, 0); push(32'h220, 0, 0);
        run(6);
        chk("R8", "raw same line held", obs[t(1)], 0);
        chk("R4", "other line passes", obs[t(2)], 1);
        cpl_req.push_back(t(0)); run(4);
        chk("R8", "raw after completion", obs[t(1)], 1);
        drain();
        push(32'h300, 0, 0); push(32'h310, 0, 0); push(32'h31F, 1, 0);
        run(6);
        chk("R9", "read read same line", obs[t(1)], 1);
        chk("R8", "war held", obs[t(2)], 0);
        drain();
        push(32'h400, 2, 0); push(32'h404, 0, 0);
        run(6);
        chk("R8", "read behind flush held", obs[t(1)], 0);
        drain();

        // R10: atomic pair not split
        push(32'h600, 3, 0); push(32'h640, 0, 0);
        run(8);
        chk("R10", "beats logged", (log_q.size() >= 3), 1);
        if (log_q.size() >= 3) begin
            chk("R10", "first beat tag", log_q[0].tag, t(0));
            chk("R10", "first beat read", log_q[0].kind, 0);
            chk("R10", "second beat tag", log_q[1].tag, t(0));
            chk("R10", "second beat write", log_q[1].kind, 1);
            chk("R10", "next op after pair", log_q[2].tag, t(1));
        end
        drain();

        // R2: capacity and tag reuse
        for (int i = 0; i < 9; i++) push(32'h700 + 32'(i * 32), 0, 0);
        run(15);
        #1;
        chk("R2", "full queue not ready", enq_ready, 0);
        for (int i = 0; i < 8; i++) chk("R2", "held entry issued", obs[t(i)], 1);
        cpl_req.push_back(t(0)); run(6);
        chk("R2", "ninth reuses first tag", log_q[log_q.size() - 1].tag, t(0));
        drain();

        // R3: random mix with arbitrary completion order
        mode = 1;
        for (int i = 0; i < 300; i++)
            push({22'd0, 3'($urandom % 6), 2'd0, 5'($urandom)}, int'($urandom % 4),
                 (($urandom % 4) == 0) ? int'($urandom % 4) : 0);
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule